// File: doc/BRIEF.md
# Instruction Opcode Decoder

This block classifies one 32-bit fixed-length instruction word per enabled clock cycle. It returns an operation identifier, a flag that says whether the encoding is legal, and a flag that marks operations that may run only in supervisor state. The six-bit primary opcode in bits [31:26] picks the operation for most immediate, load, store and branch forms. For the other forms a secondary field lower in the word settles it: a 10-bit extended code, a 3-bit selector or a 2-bit selector, depending on the primary opcode.

A static two-bit model input chooses the machine flavour: 32-bit, 64-bit or legacy-compatible. Some encodings are legal only under one flavour. The decoder covers integer arithmetic and logic, immediate forms, loads and stores, branches, the system call and the privileged system operations. Encodings outside that set come out as illegal, so a later stage can raise the illegal-instruction trap. The result is registered once and is updated only when the decode enable is high.

Top module: `idec_top`

## Requirements
- R1: When only the primary opcode identifies the operation, the decoder uses that opcode alone. 14 gives OP_ADD_IMM, 15 gives OP_ADD_IMM_SH, 24 gives OP_OR_IMM, 32 gives OP_LD_W, 36 gives OP_ST_W and 18 gives OP_BR, each with valid 1.
- R2: Under primary opcodes 19 and 31, the extended code in bits [10:1] selects the operation, and bit 0 has no effect on the result. Examples: 31/266 gives OP_ADD, 19/16 gives OP_BR_LINK_REG and 19/528 gives OP_BR_COUNT_REG.
- R3: For the overflow-capable arithmetic under primary 31, extended codes xo and xo+512 decode to the same operation. Examples: 266 and 778 both give OP_ADD, and 552 gives OP_SUB.
- R4: Primary 16 is legal only when bits [25:21] hold 0–5, 8–13 or 16–20, and then gives OP_BR_COND. Any other value in that field gives valid 0.
- R5: Primary 17 with bit 1 set gives OP_SYSCALL. Primary 17 with bit 1 clear gives valid 0.
- R6: Under primary 58, bits [1:0] select the load: 0 is OP_LD_D, 1 is OP_LD_D_UPD and 2 is OP_LD_WA. Under primary 62, bits [1:0] select the store: 0 is OP_ST_D and 1 is OP_ST_D_UPD. Other values, and every model except 64-bit (model 1), give valid 0.
- R7: Under primary 30, bits [4:2] values 0, 1, 2 and 3 give OP_ROTD_CLR_L, OP_ROTD_CLR_R, OP_ROTD_CLR and OP_ROTD_INS. These are legal only in model 1. Values 4 to 7 give valid 0.
- R8: Primary 31 with extended code 150 and bit 0 set gives OP_ST_W_COND. With bit 0 clear the same code gives valid 0. Extended code 214 with bit 0 set gives OP_ST_D_COND, but only in model 1.
- R9: The segment-register moves (31/210, 242, 595, 659) and the TLB operations (31/306, 370, 566) set the supervisor flag. The segment-register moves give valid 0 in model 1.
- R10: The legacy-only operations are primary 9 (OP_DIFFZ_IMM), 31/360 or 872 (OP_ABS) and 31/264 or 776 (OP_DIFFZ). They are legal only in model 2.
- R11: Primary 2 (OP_TRAP_D_IMM), 31/21 (OP_LD_D_IDX), 31/233 or 745 (OP_MUL_D) and 31/489 or 1001 (OP_DIV_D) are legal only in model 1.
- R12: An encoding that no rule matches, or that the model forbids, gives valid 0, operation code 0 (OP_NONE) and supervisor 0.
- R13: The outputs are registered. With rst_n low at a clock edge they clear to valid 0, code 0 and supervisor 0. With dec_en low they hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_en | input | 1 | Capture a new decode result at this edge |
| model | input | 2 | Machine flavour: 0 32-bit, 1 64-bit, 2 legacy, 3 same as 0 |
| instr | input | 32 | Instruction word |
| op_out | output | 7 | Operation identifier (0 = none) |
| valid_out | output | 1 | Encoding is legal under the model |
| super_out | output | 1 | Operation is supervisor-only |

## Verification
The checker tests these rules on every cycle: an invalid result carries code 0 and no supervisor flag, reset clears the outputs, a low enable holds them, an illegal branch-option value is rejected, the system call is recognised, and the 64-bit-only primaries are refused under the other models. Only the bench scenarios can show the mapping of specific extended codes to operations: that an overflow-enable pair lands on one operation, that the store-conditional needs bit 0 set, that the supervisor flag appears on the privileged moves, and that the legacy-only operations are gated by model.

// File: rtl/idec_pkg.sv
// Package idec_pkg
// Shared types for the instruction decoder: operation identifiers, the
// model-legality classes and the per-pass decode result record.
// Assumes the operation set fits a 7-bit code, with 0 reserved for "none".
package idec_pkg;

    localparam int INSTR_W = 32;
    localparam int OP_W    = 7;
    localparam int MODEL_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 7'd0,
        OP_ADD_IMM, OP_ADD_IMM_SH, OP_ADDC_IMM, OP_ADDC_IMM_REC, OP_SUBC_IMM,
        OP_MUL_IMM, OP_CMP_IMM, OP_CMPU_IMM, OP_OR_IMM, OP_OR_IMM_SH,
        OP_XOR_IMM, OP_XOR_IMM_SH, OP_AND_IMM, OP_AND_IMM_SH,
        OP_ROT_INS, OP_ROT_MASK, OP_ROT_REG,
        OP_LD_W, OP_LD_W_UPD, OP_LD_B, OP_LD_B_UPD, OP_ST_W, OP_ST_W_UPD,
        OP_ST_B, OP_ST_B_UPD, OP_LD_H, OP_LD_H_UPD, OP_LD_HA, OP_LD_HA_UPD,
        OP_ST_H, OP_ST_H_UPD, OP_LD_MULTI, OP_ST_MULTI,
        OP_BR, OP_BR_COND, OP_TRAP_W_IMM, OP_TRAP_D_IMM, OP_DIFFZ_IMM, OP_SYSCALL,
        OP_LD_D, OP_LD_D_UPD, OP_LD_WA, OP_ST_D, OP_ST_D_UPD,
        OP_ROTD_CLR_L, OP_ROTD_CLR_R, OP_ROTD_CLR, OP_ROTD_INS,
        OP_CRF_MOVE, OP_BR_LINK_REG, OP_BR_COUNT_REG, OP_CR_AND, OP_CR_OR,
        OP_CR_XOR, OP_INSN_SYNC, OP_INT_RETURN,
        OP_ADD, OP_SUB, OP_NEG, OP_MUL_W, OP_DIV_W, OP_MUL_D, OP_DIV_D,
        OP_ABS, OP_DIFFZ, OP_AND, OP_OR, OP_XOR, OP_NOR, OP_CMP, OP_CMPU,
        OP_TRAP_W, OP_LD_W_IDX, OP_ST_W_IDX, OP_LD_D_IDX, OP_SHL_W, OP_SHR_W,
        OP_SHRA_W, OP_SPR_READ, OP_SPR_WRITE, OP_MEM_SYNC,
        OP_ST_W_COND, OP_ST_D_COND,
        OP_SEG_WRITE, OP_SEG_WRITE_IND, OP_SEG_READ, OP_SEG_READ_IND,
        OP_TLB_INV_ENTRY, OP_TLB_INV_ALL, OP_TLB_SYNC
    } op_e;

    // Which machine flavours accept an encoding
    typedef enum logic [1:0] {
        NEED_ANY    = 2'd0,
        NEED_W64    = 2'd1,
        NEED_LEGACY = 2'd2,
        NEED_NOT64  = 2'd3
    } need_e;

    typedef struct packed {
        logic  hit;
        op_e   op;
        need_e need;
        logic  sup;
    } dec_t;

    localparam dec_t DEC_MISS = '{hit: 1'b0, op: OP_NONE, need: NEED_ANY, sup: 1'b0};

    // Build a hit record
    function automatic dec_t mk(op_e o, need_e n, logic s);
        return '{hit: 1'b1, op: o, need: n, sup: s};
    endfunction

    // Model code 1 is the 64-bit flavour, 2 the legacy flavour; 0 and 3 are 32-bit
    function automatic logic model_ok(need_e n, logic [MODEL_W-1:0] m);
        case (n)
            NEED_W64:    return m == 2'd1;
            NEED_LEGACY: return m == 2'd2;
            NEED_NOT64:  return m != 2'd1;
            default:     return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/idec_primary.sv
// Module idec_primary
// Decodes the encodings fixed by the primary opcode, plus the forms that
// refine it with a short field: branch-option check, system call bit, the
// 2-bit load/store selector and the 3-bit rotate selector.
// Assumes a combinational context; model gating is applied by the caller.
module idec_primary
    import idec_pkg::*;
#(
    parameter int IW = INSTR_W
) (
    input  logic [IW-1:0] instr,
    output dec_t          res
);
    localparam int PRI_LSB = IW - 6;
    localparam int BO_LSB  = PRI_LSB - 5;

    // Legal branch-option values as a 32-entry bitmap
    function automatic logic [31:0] bo_legal_map();
        logic [31:0] m;
        for (int v = 0; v < 32; v++)
            m[v] = (v <= 5) || (v >= 8 && v <= 13) || (v >= 16 && v <= 20);
        return m;
    endfunction
    localparam logic [31:0] BO_LEGAL = bo_legal_map();

    logic [5:0] pri;
    logic [4:0] bo;
    logic [1:0] sel2;
    logic [2:0] sel3;

    assign pri  = instr[IW-1:PRI_LSB];
    assign bo   = instr[PRI_LSB-1:BO_LSB];
    assign sel2 = instr[1:0];
    assign sel3 = instr[4:2];

    // Purpose: primary-opcode lookup with short-field refinement
    always_comb begin
        res = DEC_MISS;
        case (pri)
            6'd2:  res = mk(OP_TRAP_D_IMM, NEED_W64, 1'b0);
            6'd3:  res = mk(OP_TRAP_W_IMM, NEED_ANY, 1'b0);
            6'd7:  res = mk(OP_MUL_IMM, NEED_ANY, 1'b0);
            6'd8:  res = mk(OP_SUBC_IMM, NEED_ANY, 1'b0);
            6'd9:  res = mk(OP_DIFFZ_IMM, NEED_LEGACY, 1'b0);
            6'd10: res = mk(OP_CMPU_IMM, NEED_ANY, 1'b0);
            6'd11: res = mk(OP_CMP_IMM, NEED_ANY, 1'b0);
            6'd12: res = mk(OP_ADDC_IMM, NEED_ANY, 1'b0);
            6'd13: res = mk(OP_ADDC_IMM_REC, NEED_ANY, 1'b0);
            6'd14: res = mk(OP_ADD_IMM, NEED_ANY, 1'b0);
            6'd15: res = mk(OP_ADD_IMM_SH, NEED_ANY, 1'b0);
            6'd16: if (BO_LEGAL[bo]) res = mk(OP_BR_COND, NEED_ANY, 1'b0);
            6'd17: if (instr[1]) res = mk(OP_SYSCALL, NEED_ANY, 1'b0);
            6'd18: res = mk(OP_BR, NEED_ANY, 1'b0);
            6'd20: res = mk(OP_ROT_INS, NEED_ANY, 1'b0);
            6'd21: res = mk(OP_ROT_MASK, NEED_ANY, 1'b0);
            6'd23: res = mk(OP_ROT_REG, NEED_ANY, 1'b0);
            6'd24: res = mk(OP_OR_IMM, NEED_ANY, 1'b0);
            6'd25: res = mk(OP_OR_IMM_SH, NEED_ANY, 1'b0);
            6'd26: res = mk(OP_XOR_IMM, NEED_ANY, 1'b0);
            6'd27: res = mk(OP_XOR_IMM_SH, NEED_ANY, 1'b0);
            6'd28: res = mk(OP_AND_IMM, NEED_ANY, 1'b0);
            6'd29: res = mk(OP_AND_IMM_SH, NEED_ANY, 1'b0);
            6'd30: begin
                case (sel3)
                    3'd0: res = mk(OP_ROTD_CLR_L, NEED_W64, 1'b0);
                    3'd1: res = mk(OP_ROTD_CLR_R, NEED_W64, 1'b0);
                    3'd2: res = mk(OP_ROTD_CLR, NEED_W64, 1'b0);
                    3'd3: res = mk(OP_ROTD_INS, NEED_W64, 1'b0);
                    default: res = DEC_MISS;
                endcase
            end
            6'd32: res = mk(OP_LD_W, NEED_ANY, 1'b0);
            6'd33: res = mk(OP_LD_W_UPD, NEED_ANY, 1'b0);
            6'd34: res = mk(OP_LD_B, NEED_ANY, 1'b0);
            6'd35: res = mk(OP_LD_B_UPD, NEED_ANY, 1'b0);
            6'd36: res = mk(OP_ST_W, NEED_ANY, 1'b0);
            6'd37: res = mk(OP_ST_W_UPD, NEED_ANY, 1'b0);
            6'd38: res = mk(OP_ST_B, NEED_ANY, 1'b0);
            6'd39: res = mk(OP_ST_B_UPD, NEED_ANY, 1'b0);
            6'd40: res = mk(OP_LD_H, NEED_ANY, 1'b0);
            6'd41: res = mk(OP_LD_H_UPD, NEED_ANY, 1'b0);
            6'd42: res = mk(OP_LD_HA, NEED_ANY, 1'b0);
            6'd43: res = mk(OP_LD_HA_UPD, NEED_ANY, 1'b0);
            6'd44: res = mk(OP_ST_H, NEED_ANY, 1'b0);
            6'd45: res = mk(OP_ST_H_UPD, NEED_ANY, 1'b0);
            6'd46: res = mk(OP_LD_MULTI, NEED_ANY, 1'b0);
            6'd47: res = mk(OP_ST_MULTI, NEED_ANY, 1'b0);
            6'd58: begin
                case (sel2)
                    2'd0: res = mk(OP_LD_D, NEED_W64, 1'b0);
                    2'd1: res = mk(OP_LD_D_UPD, NEED_W64, 1'b0);
                    2'd2: res = mk(OP_LD_WA, NEED_W64, 1'b0);
                    default: res = DEC_MISS;
                endcase
            end
            6'd62: begin
                case (sel2)
                    2'd0: res = mk(OP_ST_D, NEED_W64, 1'b0);
                    2'd1: res = mk(OP_ST_D_UPD, NEED_W64, 1'b0);
                    default: res = DEC_MISS;
                endcase
            end
            default: res = DEC_MISS;
        endcase
    end

endmodule

// File: rtl/idec_extended.sv
// Module idec_extended
// Decodes primary opcodes 19 and 31 from the 10-bit extended field in the
// low bits above bit 0. For primary 31 a second lookup ignores the top bit
// of the field, so the overflow-enabled forms share one operation.
// Assumes bit 0 is a record flag, except for the store-conditional forms.
module idec_extended
    import idec_pkg::*;
#(
    parameter int IW   = INSTR_W,
    parameter int XO_W = 10
) (
    input  logic [IW-1:0] instr,
    output dec_t          res
);
    localparam int PRI_LSB = IW - 6;

    logic [5:0]      pri;
    logic [XO_W-1:0] xo;
    logic [XO_W-2:0] xo_low;
    logic            rec;
    dec_t            full31, oe31, ext19;

    assign pri    = instr[IW-1:PRI_LSB];
    assign xo     = instr[XO_W:1];
    assign xo_low = xo[XO_W-2:0];
    assign rec    = instr[0];

    // Purpose: condition-register and branch-to-register group (primary 19)
    always_comb begin
        case (xo)
            10'd0:   ext19 = mk(OP_CRF_MOVE, NEED_ANY, 1'b0);
            10'd16:  ext19 = mk(OP_BR_LINK_REG, NEED_ANY, 1'b0);
            10'd528: ext19 = mk(OP_BR_COUNT_REG, NEED_ANY, 1'b0);
            10'd257: ext19 = mk(OP_CR_AND, NEED_ANY, 1'b0);
            10'd449: ext19 = mk(OP_CR_OR, NEED_ANY, 1'b0);
            10'd193: ext19 = mk(OP_CR_XOR, NEED_ANY, 1'b0);
            10'd150: ext19 = mk(OP_INSN_SYNC, NEED_ANY, 1'b0);
            10'd50:  ext19 = mk(OP_INT_RETURN, NEED_ANY, 1'b0);
            default: ext19 = DEC_MISS;
        endcase
    end

    // Purpose: exact 10-bit match for primary 31
    always_comb begin
        case (xo)
            10'd28:  full31 = mk(OP_AND, NEED_ANY, 1'b0);
            10'd444: full31 = mk(OP_OR, NEED_ANY, 1'b0);
            10'd316: full31 = mk(OP_XOR, NEED_ANY, 1'b0);
            10'd124: full31 = mk(OP_NOR, NEED_ANY, 1'b0);
            10'd0:   full31 = mk(OP_CMP, NEED_ANY, 1'b0);
            10'd32:  full31 = mk(OP_CMPU, NEED_ANY, 1'b0);
            10'd4:   full31 = mk(OP_TRAP_W, NEED_ANY, 1'b0);
            10'd23:  full31 = mk(OP_LD_W_IDX, NEED_ANY, 1'b0);
            10'd151: full31 = mk(OP_ST_W_IDX, NEED_ANY, 1'b0);
            10'd21:  full31 = mk(OP_LD_D_IDX, NEED_W64, 1'b0);
            10'd24:  full31 = mk(OP_SHL_W, NEED_ANY, 1'b0);
            10'd536: full31 = mk(OP_SHR_W, NEED_ANY, 1'b0);
            10'd792: full31 = mk(OP_SHRA_W, NEED_ANY, 1'b0);
            10'd339: full31 = mk(OP_SPR_READ, NEED_ANY, 1'b0);
            10'd467: full31 = mk(OP_SPR_WRITE, NEED_ANY, 1'b0);
            10'd598: full31 = mk(OP_MEM_SYNC, NEED_ANY, 1'b0);
            10'd150: full31 = rec ? mk(OP_ST_W_COND, NEED_ANY, 1'b0) : DEC_MISS;
            10'd214: full31 = rec ? mk(OP_ST_D_COND, NEED_W64, 1'b0) : DEC_MISS;
            10'd210: full31 = mk(OP_SEG_WRITE, NEED_NOT64, 1'b1);
            10'd242: full31 = mk(OP_SEG_WRITE_IND, NEED_NOT64, 1'b1);
            10'd595: full31 = mk(OP_SEG_READ, NEED_NOT64, 1'b1);
            10'd659: full31 = mk(OP_SEG_READ_IND, NEED_NOT64, 1'b1);
            10'd306: full31 = mk(OP_TLB_INV_ENTRY, NEED_ANY, 1'b1);
            10'd370: full31 = mk(OP_TLB_INV_ALL, NEED_ANY, 1'b1);
            10'd566: full31 = mk(OP_TLB_SYNC, NEED_ANY, 1'b1);
            default: full31 = DEC_MISS;
        endcase
    end

    // Purpose: 9-bit match for overflow-capable arithmetic (top bit ignored)
    always_comb begin
        case (xo_low)
            9'd266: oe31 = mk(OP_ADD, NEED_ANY, 1'b0);
            9'd40:  oe31 = mk(OP_SUB, NEED_ANY, 1'b0);
            9'd104: oe31 = mk(OP_NEG, NEED_ANY, 1'b0);
            9'd235: oe31 = mk(OP_MUL_W, NEED_ANY, 1'b0);
            9'd491: oe31 = mk(OP_DIV_W, NEED_ANY, 1'b0);
            9'd233: oe31 = mk(OP_MUL_D, NEED_W64, 1'b0);
            9'd489: oe31 = mk(OP_DIV_D, NEED_W64, 1'b0);
            9'd360: oe31 = mk(OP_ABS, NEED_LEGACY, 1'b0);
            9'd264: oe31 = mk(OP_DIFFZ, NEED_LEGACY, 1'b0);
            default: oe31 = DEC_MISS;
        endcase
    end

    // Purpose: choose the group by primary opcode; exact match first
    always_comb begin
        if (pri == 6'd19)
            res = ext19;
        else if (pri == 6'd31)
            res = full31.hit ? full31 : oe31;
        else
            res = DEC_MISS;
    end

endmodule

// File: rtl/idec_top.sv
// Module idec_top
// Instruction decoder top: merges the primary and extended passes, applies
// the model legality gate and registers the result under dec_en.
// Assumes model is static while decoding; reset is synchronous, active low.
module idec_top
    import idec_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int OW = OP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_en,
    input  logic [1:0]    model,
    input  logic [IW-1:0] instr,
    output logic [OW-1:0] op_out,
    output logic          valid_out,
    output logic          super_out
);
    dec_t pri_res, ext_res, pick;
    logic legal;

    idec_primary #(.IW(IW)) u_pri (.instr(instr), .res(pri_res));
    idec_extended #(.IW(IW)) u_ext (.instr(instr), .res(ext_res));

    // Purpose: primary pass has priority; model gate decides legality
    always_comb begin
        pick  = pri_res.hit ? pri_res : ext_res;
        legal = pick.hit && model_ok(pick.need, model);
    end

    // Purpose: output register with hold and synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_out    <= '0;
            valid_out <= 1'b0;
            super_out <= 1'b0;
        end else if (dec_en) begin
            op_out    <= legal ? OW'(pick.op) : '0;
            valid_out <= legal;
            super_out <= legal && pick.sup;
        end
    end

endmodule

// File: rtl/idec_checker.sv
// Module idec_checker
// Cycle-by-cycle properties of the decoder's registered outputs.
// Assumes it is bound to idec_top with matching port names.
module idec_checker
    import idec_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        dec_en,
    input logic [1:0]  model,
    input logic [31:0] instr,
    input logic [6:0]  op_out,
    input logic        valid_out,
    input logic        super_out
);
    logic [5:0] pri;
    logic [4:0] bo;
    assign pri = instr[31:26];
    assign bo  = instr[25:21];

    assert_invalid_is_none_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> (op_out == 7'd0 && !super_out));

    assert_super_implies_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        super_out |-> valid_out);

    assert_reset_clears_R13: assert property (@(posedge clk)
        !rst_n |=> (!valid_out && op_out == 7'd0 && !super_out));

    assert_hold_when_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> ($stable(op_out) && $stable(valid_out) && $stable(super_out)));

    assert_bad_branch_option_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && pri == 6'd16 && (bo == 5'd6 || bo == 5'd7 || bo == 5'd14 ||
                                    bo == 5'd15 || bo > 5'd20)) |=> !valid_out);

    assert_syscall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && pri == 6'd17 && instr[1]) |=> (valid_out && op_out == 7'(OP_SYSCALL)));

    assert_wide_ldst_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && model != 2'd1 && (pri == 6'd58 || pri == 6'd62)) |=> !valid_out);

    assert_wide_rotate_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && model != 2'd1 && pri == 6'd30) |=> !valid_out);

endmodule

bind idec_top idec_checker u_chk (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .model(model), .instr(instr),
    .op_out(op_out), .valid_out(valid_out), .super_out(super_out)
);

// File: tb/sim_idec_top.sv
`timescale 1ns/1ps
module sim_idec_top;
    import idec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_en = 1'b0;
    logic [1:0]  model = 2'd0;
    logic [31:0] instr = 32'd0;
    logic [6:0]  op_out;
    logic        valid_out, super_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    idec_top u0 (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .model(model), .instr(instr),
        .op_out(op_out), .valid_out(valid_out), .super_out(super_out)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic [31:0] ins;
        logic [6:0]  op;
        logic        v;
        logic        s;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{2'd0, {6'd14, 26'd0},                  OP_ADD_IMM,      1'b1, 1'b0, 4'd1},  // R1
        '{2'd0, {6'd15, 26'h3ff},                OP_ADD_IMM_SH,   1'b1, 1'b0, 4'd1},  // R1
        '{2'd0, {6'd24, 26'd0},                  OP_OR_IMM,       1'b1, 1'b0, 4'd1},  // R1
        '{2'd0, {6'd32, 26'h1234},               OP_LD_W,         1'b1, 1'b0, 4'd1},  // R1
        '{2'd0, {6'd36, 26'd0},                  OP_ST_W,         1'b1, 1'b0, 4'd1},  // R1
        '{2'd0, {6'd18, 26'd5},                  OP_BR,           1'b1, 1'b0, 4'd1},  // R1
        '{2'd0, {6'd31, 15'd0, 10'd266, 1'b0},   OP_ADD,          1'b1, 1'b0, 4'd2},  // R2
        '{2'd0, {6'd31, 15'd0, 10'd266, 1'b1},   OP_ADD,          1'b1, 1'b0, 4'd2},  // R2 record bit
        '{2'd0, {6'd31, 15'd0, 10'd778, 1'b0},   OP_ADD,          1'b1, 1'b0, 4'd3},  // R3
        '{2'd0, {6'd31, 15'd0, 10'd552, 1'b1},   OP_SUB,          1'b1, 1'b0, 4'd3},  // R3
        '{2'd0, {6'd19, 15'd0, 10'd16, 1'b0},    OP_BR_LINK_REG,  1'b1, 1'b0, 4'd2},  // R2
        '{2'd0, {6'd19, 15'd0, 10'd528, 1'b0},   OP_BR_COUNT_REG, 1'b1, 1'b0, 4'd2},  // R2
        '{2'd0, {6'd16, 5'd20, 21'd0},           OP_BR_COND,      1'b1, 1'b0, 4'd4},  // R4
        '{2'd0, {6'd16, 5'd8, 21'd0},            OP_BR_COND,      1'b1, 1'b0, 4'd4},  // R4
        '{2'd0, {6'd16, 5'd6, 21'd0},            OP_NONE,         1'b0, 1'b0, 4'd4},  // R4
        '{2'd0, {6'd16, 5'd21, 21'd0},           OP_NONE,         1'b0, 1'b0, 4'd4},  // R4
        '{2'd0, {6'd17, 24'd0, 2'b10},           OP_SYSCALL,      1'b1, 1'b0, 4'd5},  // R5
        '{2'd0, {6'd17, 24'd0, 2'b01},           OP_NONE,         1'b0, 1'b0, 4'd5},  // R5
        '{2'd1, {6'd58, 24'd0, 2'd2},            OP_LD_WA,        1'b1, 1'b0, 4'd6},  // R6
        '{2'd1, {6'd58, 24'd0, 2'd3},            OP_NONE,         1'b0, 1'b0, 4'd6},  // R6
        '{2'd1, {6'd62, 24'd0, 2'd1},            OP_ST_D_UPD,     1'b1, 1'b0, 4'd6},  // R6
        '{2'd1, {6'd62, 24'd0, 2'd2},            OP_NONE,         1'b0, 1'b0, 4'd6},  // R6
        '{2'd0, {6'd58, 26'd0},                  OP_NONE,         1'b0, 1'b0, 4'd6},  // R6
        '{2'd1, {6'd30, 21'd0, 3'd3, 2'd0},      OP_ROTD_INS,     1'b1, 1'b0, 4'd7},  // R7
        '{2'd1, {6'd30, 21'd0, 3'd4, 2'd0},      OP_NONE,         1'b0, 1'b0, 4'd7},  // R7
        '{2'd0, {6'd30, 26'd0},                  OP_NONE,         1'b0, 1'b0, 4'd7},  // R7
        '{2'd0, {6'd31, 15'd0, 10'd150, 1'b1},   OP_ST_W_COND,    1'b1, 1'b0, 4'd8},  // R8
        '{2'd0, {6'd31, 15'd0, 10'd150, 1'b0},   OP_NONE,         1'b0, 1'b0, 4'd8},  // R8
        '{2'd1, {6'd31, 15'd0, 10'd214, 1'b1},   OP_ST_D_COND,    1'b1, 1'b0, 4'd8},  // R8
        '{2'd0, {6'd31, 15'd0, 10'd214, 1'b1},   OP_NONE,         1'b0, 1'b0, 4'd8},  // R8
        '{2'd0, {6'd31, 15'd0, 10'd210, 1'b0},   OP_SEG_WRITE,    1'b1, 1'b1, 4'd9},  // R9
        '{2'd1, {6'd31, 15'd0, 10'd210, 1'b0},   OP_NONE,         1'b0, 1'b0, 4'd9},  // R9
        '{2'd1, {6'd31, 15'd0, 10'd566, 1'b0},   OP_TLB_SYNC,     1'b1, 1'b1, 4'd9},  // R9
        '{2'd2, {6'd9, 26'd0},                   OP_DIFFZ_IMM,    1'b1, 1'b0, 4'd10}, // R10
        '{2'd0, {6'd9, 26'd0},                   OP_NONE,         1'b0, 1'b0, 4'd10}, // R10
        '{2'd2, {6'd31, 15'd0, 10'd872, 1'b0},   OP_ABS,          1'b1, 1'b0, 4'd10}, // R10
        '{2'd0, {6'd2, 26'd0},                   OP_NONE,         1'b0, 1'b0, 4'd11}, // R11
        '{2'd1, {6'd2, 26'd0},                   OP_TRAP_D_IMM,   1'b1, 1'b0, 4'd11}, // R11
        '{2'd1, {6'd31, 15'd0, 10'd745, 1'b0},   OP_MUL_D,        1'b1, 1'b0, 4'd11}, // R11
        '{2'd0, 32'd0,                           OP_NONE,         1'b0, 1'b0, 4'd12}, // R12
        '{2'd0, {6'd31, 15'd0, 10'd1, 1'b0},     OP_NONE,         1'b0, 1'b0, 4'd12}  // R12
    };

    task automatic check(input string tag, input logic [6:0] eop, input logic ev, input logic es);
        checks++;
        if (op_out !== eop || valid_out !== ev || super_out !== es) begin
            errors++;
            $display("FAIL %s: got op=%0d v=%0b s=%0b expected op=%0d v=%0b s=%0b",
                     tag, op_out, valid_out, super_out, eop, ev, es);
        end
    endtask

    // Drive at a falling edge; the result is registered at the next rising edge
    task automatic decode(input logic [1:0] m, input logic [31:0] w);
        @(negedge clk);
        model  = m;
        instr  = w;
        dec_en = 1'b1;
        @(negedge clk);
        dec_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R13 reset state", 7'd0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            decode(VECS[i].m, VECS[i].ins);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].op, VECS[i].v, VECS[i].s);
        end

        // R13: enable low holds the earlier result
        decode(2'd0, {6'd14, 26'd0});
        @(negedge clk);
        instr = {6'd36, 26'd0};
        @(negedge clk);
        @(negedge clk);
        check("R13 hold with enable low", OP_ADD_IMM, 1'b1, 1'b0);

        // R13: reset clears a valid supervisor result
        decode(2'd0, {6'd31, 15'd0, 10'd306, 1'b0});
        check("R9 tlb invalidate supervisor", OP_TLB_INV_ENTRY, 1'b1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R13 reset clears", 7'd0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R12: model 3 behaves as 32-bit, so a 64-bit-only form stays illegal
        decode(2'd3, {6'd62, 26'd0});
        check("R12 model 3 rejects wide store", 7'd0, 1'b0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule